// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider Controller

This block divides an input clock by a programmable ratio N = B·P + A and emits one single-cycle pulse per N input cycles, intended as the feedback edge for a phase detector. A prescaler stage runs either at a fixed modulus (P = 1 or 2) or as a dual-modulus P/P+1 stage (2/3 or 4/5). A swallow counter selects P+1 for the first A prescaler cycles of each period and P for the rest, and a B counter counts prescaler cycles per period. The B counter can be bypassed, in which case it behaves as B = 1.

The configuration pins are sampled only when a period ends. A setting that breaks the legality rules raises `cfg_invalid` at once, and the divider keeps running on the last legal setting. There is no data stream at this block's edge, so there is no valid/ready handshake. All pins are plain control or status signals, and the output pulse cannot be back-pressured.

Top module: `fbdiv_ctrl`

## Requirements
- R1: In dual-modulus mode (`cfg_mode` = 1) the gap between successive output pulses equals B·P + A input cycles. For example, 2/3 with A = 0 and B = 5 gives 10.
- R2: In fixed mode (`cfg_mode` = 0), `cfg_psel` = 0 selects P = 1 and `cfg_psel` = 1 selects P = 2. The period is B·P, and `cfg_a` has no effect on it.
- R3: In dual-modulus mode, `cfg_psel` = 0 selects the pair 2/3 (P = 2) and `cfg_psel` = 1 selects 4/5 (P = 4). For example, 4/5 with A = 1 and B = 3 gives 13.
- R4: With `cfg_bbyp` = 1 in fixed mode, B acts as 1, so the period is P.
- R5: With `cfg_bbyp` = 0, a `cfg_b` below 3 is illegal. In that case `cfg_invalid` is 1 and the previous period is kept.
- R6: Dual 2/3 with A = 2 and B = 3 gives a period of 8.
- R7: Dual-modulus mode with A > B, or with `cfg_bbyp` = 1, is illegal. `cfg_invalid` is 1 in the same cycle as the inputs, and the period stays at the last legal setting.
- R8: Configuration is sampled only on the clock edge that ends a period. A change made just after a pulse leaves the current period at its old length.
- R9: `div_pulse` is high for exactly one cycle per period. When N = 1 it is high on every cycle.
- R10: While `rst_n` is low, `div_pulse` is 0. After release, the first rising edge ends the reset period (N = 1), so `div_pulse` is 1 after that edge. The setting present at that edge is then loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | 0 = fixed prescaler, 1 = dual-modulus |
| cfg_psel | input | 1 | Prescaler select (see R2, R3) |
| cfg_a | input | A_W | Swallow count A |
| cfg_b | input | B_W | Prescaler-cycle count B |
| cfg_bbyp | input | 1 | 1 = B counter bypassed (B acts as 1) |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |
| cfg_invalid | output | 1 | Current configuration inputs are illegal |

## Verification
The bench builds the block with its defaults, A_W = 5 and B_W = 8. The 5-bit A field lets A exceed small B values, which reaches the A > B rejection path. The 8-bit B field covers every listed ratio, including 4/5 with B = 6. Periods from 1 to 24 are exercised, including the N = 1 case where the pulse is held high, and a configuration change made just after a pulse to probe the sampling boundary.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int P_W = 3;
  typedef enum logic {PS_FIXED = 1'b0, PS_DUAL = 1'b1} ps_mode_e;
endpackage

// File: rtl/fbdiv_cfg_check.sv
module fbdiv_cfg_check
  import fbdiv_pkg::*;
#(
  parameter int A_W = 5,
  parameter int B_W = 8
) (
  input  logic           mode_i,
  input  logic           psel_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic           bbyp_i,
  output logic           valid_o,
  output logic [P_W-1:0] p_o,
  output logic [A_W-1:0] a_o,
  output logic [B_W-1:0] b_o
);
  localparam int B_MIN = 3;
  ps_mode_e mode;

  always_comb begin
    mode = ps_mode_e'(mode_i);
    if (mode == PS_DUAL) p_o = psel_i ? P_W'(4) : P_W'(2);
    else                 p_o = psel_i ? P_W'(2) : P_W'(1);
    a_o = (mode == PS_DUAL) ? a_i : '0;
    b_o = bbyp_i ? B_W'(1) : b_i;
    if (bbyp_i) valid_o = (mode == PS_FIXED);
    else        valid_o = (int'(b_i) >= B_MIN) &&
                          ((mode == PS_FIXED) || (int'(a_i) <= int'(b_i)));
  end
endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler
  import fbdiv_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           plus_i,
  input  logic [P_W-1:0] p_i,
  output logic           tick_o
);
  logic [P_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= plus_i ? p_i : p_i - P_W'(1);
    else             cnt_q <= cnt_q - P_W'(1);
  end
endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow #(
  parameter int A_W = 5,
  parameter int B_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic [A_W-1:0] ld_a_i,
  input  logic [B_W-1:0] ld_b_i,
  output logic           last_o,
  output logic           plus_o
);
  logic [A_W-1:0] ac_q;
  logic [B_W-1:0] bc_q;

  assign last_o = (bc_q == '0);
  assign plus_o = last_o ? (ld_a_i != '0) : (ac_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q <= '0;
      bc_q <= '0;
    end else if (tick_i) begin
      if (last_o) begin
        ac_q <= (ld_a_i != '0) ? ld_a_i - A_W'(1) : '0;
        bc_q <= ld_b_i - B_W'(1);
      end else begin
        ac_q <= (ac_q != '0) ? ac_q - A_W'(1) : '0;
        bc_q <= bc_q - B_W'(1);
      end
    end
  end
endmodule

// File: rtl/fbdiv_ctrl.sv
module fbdiv_ctrl
  import fbdiv_pkg::*;
#(
  parameter int A_W = 5,
  parameter int B_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_mode,
  input  logic           cfg_psel,
  input  logic [A_W-1:0] cfg_a,
  input  logic [B_W-1:0] cfg_b,
  input  logic           cfg_bbyp,
  output logic           div_pulse,
  output logic           cfg_invalid
);
  logic           chk_valid;
  logic [P_W-1:0] dec_p, act_p, nxt_p, pre_p;
  logic [A_W-1:0] dec_a, act_a, nxt_a;
  logic [B_W-1:0] dec_b, act_b, nxt_b;
  logic           pre_tick, sw_last, sw_plus, wrap;

  fbdiv_cfg_check #(.A_W(A_W), .B_W(B_W)) u_chk (
    .mode_i(cfg_mode), .psel_i(cfg_psel), .a_i(cfg_a), .b_i(cfg_b),
    .bbyp_i(cfg_bbyp), .valid_o(chk_valid), .p_o(dec_p), .a_o(dec_a),
    .b_o(dec_b)
  );

  assign cfg_invalid = !chk_valid;
  assign nxt_p = chk_valid ? dec_p : act_p;
  assign nxt_a = chk_valid ? dec_a : act_a;
  assign nxt_b = chk_valid ? dec_b : act_b;
  assign wrap  = pre_tick && sw_last;
  assign pre_p = wrap ? nxt_p : act_p;

  fbdiv_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .plus_i(sw_plus), .p_i(pre_p), .tick_o(pre_tick)
  );

  fbdiv_swallow #(.A_W(A_W), .B_W(B_W)) u_sw (
    .clk(clk), .rst_n(rst_n), .tick_i(pre_tick), .ld_a_i(nxt_a),
    .ld_b_i(nxt_b), .last_o(sw_last), .plus_o(sw_plus)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_p     <= P_W'(1);
      act_a     <= '0;
      act_b     <= B_W'(1);
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= wrap;
      if (wrap) begin
        act_p <= nxt_p;
        act_a <= nxt_a;
        act_b <= nxt_b;
      end
    end
  end
endmodule

// File: rtl/fbdiv_ctrl_chk.sv
module fbdiv_ctrl_chk #(
  parameter int A_W = 5,
  parameter int B_W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_mode,
  input logic           cfg_psel,
  input logic [A_W-1:0] cfg_a,
  input logic [B_W-1:0] cfg_b,
  input logic           cfg_bbyp,
  input logic           wrap,
  input logic           div_pulse,
  input logic           cfg_invalid
);
  int gap_q, per_q, per_in;

  always_comb begin
    int p;
    if (cfg_mode) p = cfg_psel ? 4 : 2;
    else          p = cfg_psel ? 2 : 1;
    per_in = (cfg_bbyp ? 1 : int'(cfg_b)) * p + (cfg_mode ? int'(cfg_a) : 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= 0;
      per_q <= 1;
    end else if (wrap) begin
      gap_q <= 0;
      if (!cfg_invalid) per_q <= per_in;
    end else begin
      gap_q <= gap_q + 1;
    end
  end

  AST_PERIOD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> gap_q == per_q - 1); // R1
  AST_NO_LATE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |-> gap_q < per_q - 1); // R9
  AST_PULSE_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> div_pulse); // R9
  AST_QUIET_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> !div_pulse); // R9
  AST_SHORT_B_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_bbyp && int'(cfg_b) < 3) |-> cfg_invalid); // R5
  AST_A_OVER_B_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && (cfg_bbyp || int'(cfg_a) > int'(cfg_b))) |-> cfg_invalid); // R7
endmodule

bind fbdiv_ctrl fbdiv_ctrl_chk #(.A_W(A_W), .B_W(B_W)) u_ast (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_psel(cfg_psel),
  .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_bbyp(cfg_bbyp), .wrap(wrap),
  .div_pulse(div_pulse), .cfg_invalid(cfg_invalid)
);

// File: tb/fbdiv_ctrl_tb.sv
`timescale 1ns/1ps
module fbdiv_ctrl_tb_top;
  localparam int A_W = 5;
  localparam int B_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_mode = 1'b0, cfg_psel = 1'b0, cfg_bbyp = 1'b1;
  logic [A_W-1:0] cfg_a = '0;
  logic [B_W-1:0] cfg_b = '0;
  logic div_pulse, cfg_invalid;

  int n_cmp = 0, n_bad = 0;
  string tag = "R10";
  bit done = 0;

  always #2.5 clk = ~clk;

  fbdiv_ctrl #(.A_W(A_W), .B_W(B_W)) dut_i (.*);

  function automatic bit ref_valid();
    if (cfg_bbyp) return !cfg_mode;
    return (int'(cfg_b) >= 3) && (!cfg_mode || int'(cfg_a) <= int'(cfg_b));
  endfunction

  function automatic int ref_n();
    int p;
    p = cfg_mode ? (cfg_psel ? 4 : 2) : (cfg_psel ? 2 : 1);
    return (cfg_bbyp ? 1 : int'(cfg_b)) * p + (cfg_mode ? int'(cfg_a) : 0);
  endfunction

  // behavioural reference: cycles remaining in the current period
  int rem = 0, nact = 1;
  bit pexp = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      rem = 0; nact = 1; pexp = 0;
    end else begin
      pexp = (rem == 0);
      if (rem == 0) begin
        if (ref_valid()) nact = ref_n();
        rem = nact - 1;
      end else rem = rem - 1;
    end
  end

  task automatic check(bit got, bit exp, string t, string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", t, what, got, exp, $time);
    end
  endtask

  task automatic check_int(int got, int exp, string t);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s period: actual %0d expected %0d", t, got, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    check(div_pulse, rst_n ? pexp : 1'b0, tag, "div_pulse");
    check(cfg_invalid, !ref_valid(), "R7", "cfg_invalid");
  end

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic wait_pulse();
    do step(); while (!div_pulse);
  endtask

  task automatic gap(int exp, string t);
    int c = 0;
    do begin step(); c++; end while (!div_pulse);
    check_int(c, exp, t);
  endtask

  task automatic set(bit m, bit ps, int a, int b, bit by, string t);
    cfg_mode = m; cfg_psel = ps; cfg_a = A_W'(a); cfg_b = B_W'(b); cfg_bbyp = by;
    tag = t;
  endtask

  task automatic run(bit m, bit ps, int a, int b, bit by, int exp, string t);
    set(m, ps, a, b, by, t);
    wait_pulse();
    gap(exp, t);
    gap(exp, t);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) step();
    check(div_pulse, 1'b0, "R10", "reset");
    @(negedge clk); rst_n = 1'b1;
    step();
    check(div_pulse, 1'b1, "R10", "first pulse");
    gap(1, "R9");
    gap(1, "R9");
    run(0, 1, 0, 0, 1, 2, "R4");
    run(0, 0, 0, 3, 0, 3, "R2");
    run(0, 1, 9, 5, 0, 10, "R2");
    run(1, 0, 2, 3, 0, 8, "R6");
    run(1, 0, 0, 5, 0, 10, "R1");
    run(1, 0, 1, 4, 0, 9, "R1");
    run(1, 1, 1, 3, 0, 13, "R3");
    run(1, 1, 0, 6, 0, 24, "R3");
    run(1, 1, 5, 3, 0, 24, "R7");
    check(cfg_invalid, 1'b1, "R7", "a over b");
    run(0, 0, 0, 2, 0, 24, "R5");
    check(cfg_invalid, 1'b1, "R5", "short b");
    run(1, 0, 0, 4, 1, 24, "R7");
    set(1, 1, 0, 6, 0, "R8");
    wait_pulse();
    set(0, 0, 0, 3, 0, "R8");
    gap(24, "R8");
    gap(3, "R8");
    repeat (5) step();
    finish_up();
  end
endmodule